// File: doc/BRIEF.md
# Non-Volatile Array Command Sequencer

This block is the command front end of a small non-volatile word array. Software starts every operation with three writes in a fixed order. It first writes a full, aligned data word to an array address. It then writes an operation code to the command register. Finally it writes 1 to the buffer-empty bit of the status register, which launches the operation. Each write is checked against the launch protocol. Any write out of order, any partial write and any unknown operation code raises an access error and drops the sequence in progress.

A launched operation waits in a one-entry pending slot. It moves into the execution unit as soon as that unit is free. The execution unit times program, sector erase, mass erase, erase verify and sector modify with cycle counters and then applies the result to an internal register array. Because the buffer-empty flag returns as soon as a command starts executing, software can buffer a second command while the first one runs. A per-sector protection input, write-1-to-clear error flags, a stop request that aborts execution, and two interrupt enables complete the block.

Register map (byte offset when the register space is selected): 0 divider (a write marks the divider as loaded, read returns {loaded, value[6:0]}), 1 configuration (bit 0 buffer-empty interrupt enable, bit 1 command-complete interrupt enable), 2 status, 3 command. Status bits: 7 buffer-empty, 6 command-complete (read only), 5 protection violation, 4 access error, 2 blank. Bits 5, 4 and 2 are cleared by writing 1. A sector is an even/odd word pair. Erased words read 0xFFFF.

Top module: `nvm_cmd_seq`

## Requirements
- R1: After reset, status reads 0xC0 (buffer-empty and complete set, all error and blank flags clear), every array word reads 0xFFFF, and irq is low.
- R2: Program (code 0x20) ANDs the buffered data into the addressed word, and complete stays low for at least T_PROG cycles after launch.
- R3: The legal codes are 0x20 program, 0x40 sector erase, 0x41 mass erase, 0x05 erase verify and 0x60 sector modify. Writing any other code sets the access error flag, and nothing executes.
- R4: An array write made before the divider register has ever been written sets the access error flag.
- R5: An array write with either byte enable low, or with byte address bit 0 set, sets the access error flag.
- R6: Each of these sets the access error flag and abandons the sequence: an array write while buffer-empty is low (including a second word), a write to any register other than command after the word, a command write with no word buffered, a second command write, and any write other than the launch after the command.
- R7: Writing the status register with bit 7 low after the command aborts the sequence and sets the access error flag. No execution follows, and complete stays high.
- R8: A program, sector erase or sector modify aimed at a sector whose prot_sect bit is set, or a mass erase while any prot_sect bit is set, sets the protection violation flag when the command is written. Nothing executes.
- R9: A launch made while the access error or protection violation flag is set is discarded. Writing 1 to a flag bit clears it.
- R10: Sector erase sets both words of the addressed sector to 0xFFFF. Mass erase sets every word to 0xFFFF. Sector modify erases the sector and then programs the addressed word.
- R11: Erase verify (0x05) sets the blank flag only if every array word is 0xFFFF.
- R12: Buffer-empty returns high once a launched command starts executing, so a second command can be queued. The queued command runs after the first one finishes. Complete is high only when no command is pending or executing.
- R13: irq equals (buffer-empty AND configuration bit 0) OR (complete AND configuration bit 1).
- R14: A rising edge on stop_req during execution aborts the command, leaves the array unchanged, drops any pending command and sets the access error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_sel | input | 1 | 1 selects the array space, 0 selects the register space |
| bus_addr | input | AW+1 | Byte address (register offset in bits 1:0 when bus_sel is 0) |
| bus_be | input | 2 | Byte enables for array writes |
| bus_wdata | input | 16 | Write data (registers use bits 7:0) |
| bus_rdata | output | 16 | Combinational read of the selected register or array word |
| prot_sect | input | 2**(AW-1) | One protection bit per sector |
| stop_req | input | 1 | Stop request; a rising edge aborts execution |
| irq | output | 1 | Interrupt request |

## Verification
The main path is driven from a table of operations. Each row pairs a code, a word address, data and a protection pattern. Successive rows include an AND of a second program over a first, an illegal code, protected and unprotected sectors, a masked mass erase, and erase verify on a non-blank array and then on a blank one. Together these rows separate the AND-merge from an overwrite, a sector erase from a word erase, and a protection check against the addressed sector from one against the whole mask. Directed sequences then cover each out-of-order write, the abort by writing 0, a launch blocked by a standing error, and two commands chosen so that a swapped execution order leaves a different word value. They also cover the interrupt enables and a stop request in the middle of a mass erase.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    localparam int NVM_DW = 16;

    // operation codes
    localparam logic [7:0] OPC_PROG   = 8'h20;
    localparam logic [7:0] OPC_SERASE = 8'h40;
    localparam logic [7:0] OPC_MERASE = 8'h41;
    localparam logic [7:0] OPC_VERIFY = 8'h05;
    localparam logic [7:0] OPC_MODIFY = 8'h60;

    // register offsets
    localparam logic [1:0] REG_DIV  = 2'd0;
    localparam logic [1:0] REG_CFG  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_CMD  = 2'd3;

    // status bit positions
    localparam int ST_BUFE  = 7;
    localparam int ST_DONE  = 6;
    localparam int ST_PVIO  = 5;
    localparam int ST_ACCE  = 4;
    localparam int ST_BLANK = 2;

    typedef enum logic [1:0] {PH_IDLE, PH_WORD, PH_CMD} seq_phase_e;
    typedef enum logic [1:0] {EX_IDLE, EX_RUN, EX_MODPROG} exec_state_e;
    typedef enum logic [1:0] {ARR_NONE, ARR_AND, ARR_SECT, ARR_ALL} arr_op_e;

    typedef struct packed {
        logic [7:0]        opc;
        logic [NVM_DW-1:0] data;
    } nvm_req_t;

    function automatic logic opc_legal(input logic [7:0] c);
        case (c)
            OPC_PROG, OPC_SERASE, OPC_MERASE, OPC_VERIFY, OPC_MODIFY: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  arr_op_e           op,
    input  logic [AW-1:0]     op_waddr,
    input  logic [NVM_DW-1:0] op_data,
    input  logic [AW-1:0]     rd_waddr,
    output logic [NVM_DW-1:0] rd_data,
    output logic              all_erased
);
    localparam int NW = 1 << AW;
    localparam logic [NVM_DW-1:0] ERASED = '1;

    logic [NVM_DW-1:0] mem [NW];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NW; i++) mem[i] <= ERASED;
        end else begin
            case (op)
                ARR_AND:  mem[op_waddr] <= mem[op_waddr] & op_data;
                ARR_SECT: begin
                    mem[{op_waddr[AW-1:1], 1'b0}] <= ERASED;
                    mem[{op_waddr[AW-1:1], 1'b1}] <= ERASED;
                end
                ARR_ALL:  for (int i = 0; i < NW; i++) mem[i] <= ERASED;
                default: ;
            endcase
        end
    end

    assign rd_data = mem[rd_waddr];

    always_comb begin
        all_erased = 1'b1;
        for (int i = 0; i < NW; i++)
            if (mem[i] != ERASED) all_erased = 1'b0;
    end

endmodule

// File: rtl/nvm_exec.sv
module nvm_exec
    import nvm_pkg::*;
#(
    parameter int AW       = 3,
    parameter int T_PROG   = 6,
    parameter int T_SERASE = 10,
    parameter int T_MERASE = 14,
    parameter int T_VERIFY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pend_v,
    input  nvm_req_t          pend_req,
    input  logic [AW-1:0]     pend_waddr,
    input  logic              stop_req,
    input  logic              all_erased,
    output logic              take,
    output logic              busy,
    output logic              abort,
    output logic              blank_set,
    output arr_op_e           arr_op,
    output logic [AW-1:0]     arr_waddr,
    output logic [NVM_DW-1:0] arr_data
);
    localparam int TA   = (T_PROG > T_SERASE) ? T_PROG : T_SERASE;
    localparam int TB   = (T_MERASE > T_VERIFY) ? T_MERASE : T_VERIFY;
    localparam int TMAX = (TA > TB) ? TA : TB;
    localparam int CW   = $clog2(TMAX + 1);

    exec_state_e   st;
    logic [CW-1:0] cnt;
    nvm_req_t      cur;
    logic [AW-1:0] cur_waddr;
    logic          stop_q;
    logic          stop_rise;
    logic          fin;

    function automatic logic [CW-1:0] first_cnt(input logic [7:0] c);
        case (c)
            OPC_PROG:               return CW'(T_PROG - 1);
            OPC_SERASE, OPC_MODIFY: return CW'(T_SERASE - 1);
            OPC_MERASE:             return CW'(T_MERASE - 1);
            default:                return CW'(T_VERIFY - 1);
        endcase
    endfunction

    assign stop_rise = stop_req && !stop_q;
    assign busy      = (st != EX_IDLE);
    assign take      = (st == EX_IDLE) && pend_v;
    assign abort     = busy && stop_rise;
    assign fin       = busy && !stop_rise && (cnt == '0);
    assign arr_waddr = cur_waddr;
    assign arr_data  = cur.data;

    always_comb begin
        arr_op    = ARR_NONE;
        blank_set = 1'b0;
        if (fin) begin
            if (st == EX_MODPROG) begin
                arr_op = ARR_AND;
            end else begin
                case (cur.opc)
                    OPC_PROG:               arr_op = ARR_AND;
                    OPC_SERASE, OPC_MODIFY: arr_op = ARR_SECT;
                    OPC_MERASE:             arr_op = ARR_ALL;
                    OPC_VERIFY:             blank_set = all_erased;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= EX_IDLE;
            cnt       <= '0;
            cur       <= '0;
            cur_waddr <= '0;
            stop_q    <= 1'b0;
        end else begin
            stop_q <= stop_req;
            if (abort) begin
                st <= EX_IDLE;
            end else if (take) begin
                st        <= EX_RUN;
                cur       <= pend_req;
                cur_waddr <= pend_waddr;
                cnt       <= first_cnt(pend_req.opc);
            end else if (busy) begin
                if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end else if (st == EX_RUN && cur.opc == OPC_MODIFY) begin
                    st  <= EX_MODPROG;
                    cnt <= CW'(T_PROG - 1);
                end else begin
                    st <= EX_IDLE;
                end
            end
        end
    end

    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != '0 && !stop_rise) |=> busy);

    // R14
    stop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && stop_rise) |=> !busy);

endmodule

// File: rtl/nvm_seq_ctrl.sv
module nvm_seq_ctrl
    import nvm_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic                   sel,
    input  logic [AW:0]            addr,
    input  logic [1:0]             be,
    input  logic [NVM_DW-1:0]      wdata,
    input  logic [(1<<(AW-1))-1:0] prot,
    input  logic                   take,
    input  logic                   abort,
    input  logic                   blank_set,
    input  logic                   exec_busy,
    output logic                   pend_v,
    output nvm_req_t               pend_req,
    output logic [AW-1:0]          pend_waddr,
    output logic [7:0]             reg_rdata,
    output logic                   irq
);
    seq_phase_e        phase, nphase;
    logic [AW-1:0]     lat_waddr;
    logic [NVM_DW-1:0] lat_data;
    logic [7:0]        lat_opc;
    logic              divld;
    logic [6:0]        divv;
    logic [1:0]        cfg;
    logic              accerr, pviol, blank;
    logic              bufe, done;
    logic              acc_hit, pv_hit, launch, word_ld, cmd_ld, prot_hit;
    logic              reg_wr, stat_wr;

    assign bufe    = (phase == PH_IDLE) && !pend_v;
    assign done    = !pend_v && !exec_busy;
    assign reg_wr  = wr && !sel;
    assign stat_wr = reg_wr && (addr[1:0] == REG_STAT);
    assign irq     = (cfg[0] && bufe) || (cfg[1] && done);

    always_comb begin
        if (wdata[7:0] == OPC_MERASE)      prot_hit = |prot;
        else if (wdata[7:0] == OPC_VERIFY) prot_hit = 1'b0;
        else                               prot_hit = prot[lat_waddr[AW-1:1]];
    end

    always_comb begin
        acc_hit = 1'b0;
        pv_hit  = 1'b0;
        launch  = 1'b0;
        word_ld = 1'b0;
        cmd_ld  = 1'b0;
        nphase  = phase;
        if (wr && sel) begin
            if (!divld || be != 2'b11 || addr[0] || !bufe) begin
                acc_hit = 1'b1;
                nphase  = PH_IDLE;
            end else begin
                word_ld = 1'b1;
                nphase  = PH_WORD;
            end
        end else if (reg_wr) begin
            case (addr[1:0])
                REG_CMD: begin
                    nphase = PH_IDLE;
                    if (phase != PH_WORD || !opc_legal(wdata[7:0])) acc_hit = 1'b1;
                    else if (prot_hit) pv_hit = 1'b1;
                    else begin
                        cmd_ld = 1'b1;
                        nphase = PH_CMD;
                    end
                end
                REG_STAT: begin
                    if (phase == PH_WORD) begin
                        acc_hit = 1'b1;
                        nphase  = PH_IDLE;
                    end else if (phase == PH_CMD) begin
                        nphase = PH_IDLE;
                        if (wdata[ST_BUFE]) launch = 1'b1;
                        else                acc_hit = 1'b1;
                    end
                end
                default: begin
                    if (phase != PH_IDLE) begin
                        acc_hit = 1'b1;
                        nphase  = PH_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            lat_waddr  <= '0;
            lat_data   <= '0;
            lat_opc    <= '0;
            divld      <= 1'b0;
            divv       <= '0;
            cfg        <= '0;
            accerr     <= 1'b0;
            pviol      <= 1'b0;
            blank      <= 1'b0;
            pend_v     <= 1'b0;
            pend_req   <= '0;
            pend_waddr <= '0;
        end else begin
            phase <= nphase;
            if (word_ld) begin
                lat_waddr <= addr[AW:1];
                lat_data  <= wdata;
            end
            if (cmd_ld) lat_opc <= wdata[7:0];
            if (reg_wr && phase == PH_IDLE && addr[1:0] == REG_DIV) begin
                divld <= 1'b1;
                divv  <= wdata[6:0];
            end
            if (reg_wr && phase == PH_IDLE && addr[1:0] == REG_CFG)
                cfg <= wdata[1:0];
            accerr <= (accerr && !(stat_wr && wdata[ST_ACCE])) || acc_hit || abort;
            pviol  <= (pviol && !(stat_wr && wdata[ST_PVIO])) || pv_hit;
            blank  <= (blank && !(stat_wr && wdata[ST_BLANK])) || blank_set;
            if (abort) begin
                pend_v <= 1'b0;
            end else if (launch && !accerr && !pviol) begin
                pend_v     <= 1'b1;
                pend_req   <= '{opc: lat_opc, data: lat_data};
                pend_waddr <= lat_waddr;
            end else if (take) begin
                pend_v <= 1'b0;
            end
        end
    end

    always_comb begin
        case (addr[1:0])
            REG_DIV:  reg_rdata = {divld, divv};
            REG_CFG:  reg_rdata = {6'b0, cfg};
            REG_STAT: reg_rdata = {bufe, done, pviol, accerr, 1'b0, blank, 2'b0};
            default:  reg_rdata = lat_opc;
        endcase
    end

    // R5
    partial_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel && be != 2'b11) |=> accerr);

    // R7
    abort_by_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && phase == PH_CMD && !wdata[ST_BUFE]) |=> (accerr && !pend_v));

    // R12
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_v && exec_busy && !abort) |=> pend_v);

endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_pkg::*;
#(
    parameter int AW       = 3,
    parameter int T_PROG   = 6,
    parameter int T_SERASE = 10,
    parameter int T_MERASE = 14,
    parameter int T_VERIFY = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic                   bus_sel,
    input  logic [AW:0]            bus_addr,
    input  logic [1:0]             bus_be,
    input  logic [15:0]            bus_wdata,
    output logic [15:0]            bus_rdata,
    input  logic [(1<<(AW-1))-1:0] prot_sect,
    input  logic                   stop_req,
    output logic                   irq
);
    logic              pend_v, take, busy, abort, blank_set, all_erased;
    nvm_req_t          pend_req;
    logic [AW-1:0]     pend_waddr, arr_waddr;
    logic [NVM_DW-1:0] arr_data, arr_rd;
    arr_op_e           arr_op;
    logic [7:0]        reg_rdata;

    nvm_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel(bus_sel), .addr(bus_addr),
        .be(bus_be), .wdata(bus_wdata), .prot(prot_sect), .take(take),
        .abort(abort), .blank_set(blank_set), .exec_busy(busy),
        .pend_v(pend_v), .pend_req(pend_req), .pend_waddr(pend_waddr),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    nvm_exec #(.AW(AW), .T_PROG(T_PROG), .T_SERASE(T_SERASE),
               .T_MERASE(T_MERASE), .T_VERIFY(T_VERIFY)) u_exec (
        .clk(clk), .rst(rst), .pend_v(pend_v), .pend_req(pend_req),
        .pend_waddr(pend_waddr), .stop_req(stop_req), .all_erased(all_erased),
        .take(take), .busy(busy), .abort(abort), .blank_set(blank_set),
        .arr_op(arr_op), .arr_waddr(arr_waddr), .arr_data(arr_data)
    );

    nvm_array #(.AW(AW)) u_array (
        .clk(clk), .rst(rst), .op(arr_op), .op_waddr(arr_waddr),
        .op_data(arr_data), .rd_waddr(bus_addr[AW:1]), .rd_data(arr_rd),
        .all_erased(all_erased)
    );

    assign bus_rdata = bus_sel ? arr_rd : {8'h00, reg_rdata};

endmodule

// File: tb/tb_nvm_cmd_seq.sv
module tb_nvm_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int NW = 1 << AW;
    localparam int T_PROG = 6;

    localparam logic [1:0] O_DIV = 2'd0, O_CFG = 2'd1, O_STAT = 2'd2, O_CMD = 2'd3;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_wr = 1'b0, bus_sel = 1'b0;
    logic [AW:0] bus_addr = '0;
    logic [1:0]  bus_be = 2'b11;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  prot_sect = '0;
    logic        stop_req = 1'b0;
    logic        irq;

    nvm_cmd_seq dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .prot_sect(prot_sect), .stop_req(stop_req),
        .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    logic [15:0] model [NW];

    typedef struct packed {
        logic [7:0]  cmd;
        logic [2:0]  wa;
        logic [15:0] d;
        logic [3:0]  prot;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{8'h20, 3'd2, 16'h1234, 4'h0},
        '{8'h20, 3'd2, 16'hFF0F, 4'h0},
        '{8'h33, 3'd2, 16'h0000, 4'h0},
        '{8'h40, 3'd2, 16'h0000, 4'h0},
        '{8'h20, 3'd5, 16'h00AA, 4'h4},
        '{8'h41, 3'd0, 16'h0000, 4'h1},
        '{8'h20, 3'd5, 16'h00AA, 4'h0},
        '{8'h60, 3'd4, 16'h5555, 4'h0},
        '{8'h05, 3'd0, 16'h0000, 4'h0},
        '{8'h41, 3'd0, 16'h0000, 4'h0},
        '{8'h05, 3'd0, 16'h0000, 4'h0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] off, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 1'b0; bus_addr = {2'b00, off};
        bus_wdata = {8'h00, v}; bus_be = 2'b11;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_arr(input logic [AW:0] ba, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = 1'b1; bus_addr = ba; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] off, output logic [7:0] v);
        bus_sel = 1'b0; bus_addr = {2'b00, off};
        #1 v = bus_rdata[7:0];
    endtask

    task automatic rd_word(input int idx, output logic [15:0] v);
        bus_sel = 1'b1; bus_addr = {idx[AW-1:0], 1'b0};
        #1 v = bus_rdata;
    endtask

    task automatic wait_done(output int n);
        logic [7:0] s;
        n = 0;
        rd_reg(O_STAT, s);
        while (!s[6] && n < 500) begin
            @(negedge clk);
            n++;
            rd_reg(O_STAT, s);
        end
    endtask

    task automatic launch(input logic [7:0] c, input int wa, input logic [15:0] d);
        wr_arr({wa[AW-1:0], 1'b0}, d, 2'b11);
        wr_reg(O_CMD, c);
        wr_reg(O_STAT, 8'h80);
    endtask

    task automatic check_stat(input string req, input logic [7:0] exp);
        logic [7:0] s;
        rd_reg(O_STAT, s);
        chk(req, {8'h00, s}, {8'h00, exp});
    endtask

    task automatic check_word(input string req, input int idx);
        logic [15:0] w;
        rd_word(idx, w);
        chk(req, w, model[idx]);
    endtask

    function automatic logic model_blank();
        for (int i = 0; i < NW; i++) if (model[i] != 16'hFFFF) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired before the run ended");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        logic [7:0] s;
        for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_stat("R1 reset status", 8'hC0);
        chk("R1 reset irq", {15'd0, irq}, 16'h0000);
        check_word("R1 reset word 0", 0);
        check_word("R1 reset word 7", 7);

        // R4 array write before divider loaded
        wr_arr(4'd0, 16'h0000, 2'b11);
        check_stat("R4 write before divider", 8'hD0);
        check_word("R4 array untouched", 0);
        wr_reg(O_STAT, 8'h34);
        check_stat("R9 w1c clears access error", 8'hC0);
        wr_reg(O_DIV, 8'h13);

        // table of operations: R2 R3 R8 R10 R11
        for (int k = 0; k < 11; k++) begin
            vec_t v;
            logic legal, phit;
            logic [7:0] exp;
            v = VECS[k];
            prot_sect = v.prot;
            legal = (v.cmd == 8'h20 || v.cmd == 8'h40 || v.cmd == 8'h41 ||
                     v.cmd == 8'h05 || v.cmd == 8'h60);
            if (v.cmd == 8'h41)      phit = |v.prot;
            else if (v.cmd == 8'h05) phit = 1'b0;
            else                     phit = v.prot[v.wa >> 1];
            wr_arr({v.wa, 1'b0}, v.d, 2'b11);
            wr_reg(O_CMD, v.cmd);
            n = 0;
            if (legal && !phit) begin
                wr_reg(O_STAT, 8'h80);
                wait_done(n);
                case (v.cmd)
                    8'h20: model[v.wa] = model[v.wa] & v.d;
                    8'h40: begin model[v.wa] = 16'hFFFF; model[v.wa ^ 3'd1] = 16'hFFFF; end
                    8'h41: for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
                    8'h60: begin
                        model[v.wa ^ 3'd1] = 16'hFFFF;
                        model[v.wa] = 16'hFFFF & v.d;
                    end
                    default: ;
                endcase
            end
            exp = 8'hC0;
            if (!legal) exp[4] = 1'b1;
            if (legal && phit) exp[5] = 1'b1;
            if (legal && !phit && v.cmd == 8'h05 && model_blank()) exp[2] = 1'b1;
            check_stat($sformatf("R3 R8 R11 status row %0d", k), exp);
            check_word($sformatf("R2 R10 word row %0d", k), v.wa);
            check_word($sformatf("R10 partner row %0d", k), v.wa ^ 3'd1);
            if (v.cmd == 8'h20 && legal && !phit)
                chk($sformatf("R2 program duration row %0d", k),
                    {15'd0, n >= T_PROG}, 16'h0001);
            wr_reg(O_STAT, 8'h34);
            prot_sect = '0;
        end

        // R5 partial and misaligned writes
        wr_arr(4'd0, 16'h0000, 2'b01);
        check_stat("R5 byte write", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        wr_arr(4'd1, 16'h0000, 2'b11);
        check_stat("R5 misaligned write", 8'hD0);
        wr_reg(O_STAT, 8'h34);

        // R6 out-of-order writes
        wr_arr(4'd0, 16'h0000, 2'b11); wr_arr(4'd2, 16'h0000, 2'b11);
        check_stat("R6 second word", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        wr_arr(4'd0, 16'h0000, 2'b11); wr_reg(O_CFG, 8'h00);
        check_stat("R6 register after word", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        wr_reg(O_CMD, 8'h20);
        check_stat("R6 command without word", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        wr_arr(4'd0, 16'h0000, 2'b11); wr_reg(O_CMD, 8'h20); wr_reg(O_CMD, 8'h20);
        check_stat("R6 second command", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        wr_arr(4'd0, 16'h0000, 2'b11); wr_reg(O_CMD, 8'h20); wr_reg(O_DIV, 8'h13);
        check_stat("R6 register after command", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        repeat (10) @(negedge clk);
        check_word("R6 nothing executed", 0);

        // R7 abort by writing 0 to buffer-empty
        wr_arr(4'd0, 16'h0000, 2'b11); wr_reg(O_CMD, 8'h20); wr_reg(O_STAT, 8'h00);
        check_stat("R7 abort flags", 8'hD0);
        repeat (10) @(negedge clk);
        check_word("R7 nothing executed", 0);
        wr_reg(O_STAT, 8'h34);

        // R9 launch blocked by standing error
        wr_arr(4'd0, 16'h0000, 2'b11); wr_reg(O_CMD, 8'h99);
        launch(8'h20, 0, 16'h0000);
        repeat (10) @(negedge clk);
        check_word("R9 blocked launch", 0);
        check_stat("R9 error still set", 8'hD0);
        wr_reg(O_STAT, 8'h34);
        check_stat("R9 cleared", 8'hC0);

        // R12 pipelined second command
        launch(8'h20, 1, 16'h0F0F);
        wait_done(n);
        model[1] = 16'h0F0F;
        launch(8'h40, 0, 16'h0000);
        @(negedge clk);
        rd_reg(O_STAT, s);
        chk("R12 buffer free while running", {8'h00, s & 8'hC0}, 16'h0080);
        launch(8'h20, 1, 16'h3C3C);
        rd_reg(O_STAT, s);
        chk("R12 queued and running", {8'h00, s & 8'hC0}, 16'h0000);
        wait_done(n);
        model[0] = 16'hFFFF; model[1] = 16'h3C3C;
        check_word("R12 order word 0", 0);
        check_word("R12 order word 1", 1);
        check_stat("R12 complete", 8'hC0);

        // R13 interrupt enables
        wr_reg(O_CFG, 8'h01);
        #1 chk("R13 buffer-empty irq", {15'd0, irq}, 16'h0001);
        wr_reg(O_CFG, 8'h00);
        #1 chk("R13 irq disabled", {15'd0, irq}, 16'h0000);
        wr_reg(O_CFG, 8'h02);
        launch(8'h20, 6, 16'hAAAA);
        #1 chk("R13 complete irq low while busy", {15'd0, irq}, 16'h0000);
        wait_done(n);
        model[6] = 16'hAAAA;
        #1 chk("R13 complete irq", {15'd0, irq}, 16'h0001);
        check_word("R13 program result", 6);
        wr_reg(O_CFG, 8'h00);

        // R14 stop during mass erase
        launch(8'h41, 0, 16'h0000);
        repeat (3) @(negedge clk);
        stop_req = 1'b1;
        repeat (2) @(negedge clk);
        stop_req = 1'b0;
        check_stat("R14 stop abort flags", 8'hD0);
        check_word("R14 array unchanged", 1);
        check_word("R14 array unchanged", 6);
        wr_reg(O_STAT, 8'h34);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule